// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows the low-power and suspend state of one single-data-rate SDRAM device as a controller drives it. On every clock edge it compares the clock-enable level it registered at the previous edge with the level present now. It combines that comparison with the decoded command and two status flags: all banks idle, and a read or write burst in progress. From these it decides whether the device enters or leaves power-down, self refresh or clock suspend, or keeps running normally.

Each decision is made from the state held just before the edge. All outputs are registered, so every result appears one clock after the edge that caused it. Leaving self refresh opens an exit window whose length is set by a parameter. During that window only inhibit or NOP commands are allowed and `ready` stays low. At least two NOPs must arrive before the window closes. Any combination of levels, state and command that the rules below do not cover raises `illegal` for one cycle.

The state names used throughout are:
- IDLE = 0
- ACTIVE = 1
- PWRDN = 2
- SELFREF = 3
- SUSPEND = 4
- SRX (self-refresh exit window) = 5

The command codes are:
- INHIBIT = 0
- NOP = 1
- ACTIVATE = 2
- READ = 3
- WRITE = 4
- PRECHARGE = 5
- AUTO_REFRESH = 6
- LOAD_MODE = 7

Top module: `sdram_cke_tracker`

## Requirements
- R1: A synchronous active-high `rst` gives `mode` = IDLE (0), `ready` = 1, `cmd_accept` = 0 and `illegal` = 0. It also presets the stored previous clock-enable to high, so a low `cke` with NOP and `banks_idle` = 1 on the first edge after reset enters PWRDN.
- R2: With `cke` low at both the previous and the current edge, PWRDN, SELFREF and SUSPEND keep their state, whatever the command, and `illegal` stays 0.
- R3: From IDLE or ACTIVE, `cke` falling (high to low) with `banks_idle` = 1 and `rw_active` = 0 enters PWRDN (2) if the command is INHIBIT (0) or NOP (1), and SELFREF (3) if the command is AUTO_REFRESH (6).
- R4: From IDLE or ACTIVE, `cke` falling with `rw_active` = 1 enters SUSPEND (4) if the command is WRITE (4) or NOP (1).
- R5: In PWRDN, `cke` rising (low to high) with INHIBIT or NOP returns to IDLE, with `ready` = 1 in the next cycle.
- R6: In SUSPEND, `cke` rising with any command returns to ACTIVE (1) with `ready` = 1.
- R7: In SELFREF, `cke` rising with INHIBIT or NOP enters SRX (5). SRX lasts exactly `SRX_CYCLES` edges with `ready` = 0, and on the last of those edges the state becomes IDLE with `ready` = 1.
- R8: In SRX, any edge where `cke` is not high on both samples, or the command is not INHIBIT or NOP, pulses `illegal`. If fewer than two NOPs are seen on the window's edges, `illegal` pulses on the closing edge.
- R9: Any other combination pulses `illegal` for one cycle and leaves `mode` unchanged. Examples are a falling `cke` with ACTIVATE, a rising `cke` with READ in PWRDN, and a low `cke` in IDLE or ACTIVE.
- R10: In IDLE or ACTIVE, `cke` high on both edges takes the command. `cmd_accept` pulses, and the state becomes IDLE if `banks_idle` = 1 and ACTIVE otherwise. `cmd_accept` never pulses together with `illegal` or in any other state.
- R11: `mode`, `cmd_accept`, `illegal` and `ready` are registered. They reflect the inputs of an edge right after that edge and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 3 | Decoded command code |
| banks_idle | input | 1 | All banks are precharged |
| rw_active | input | 1 | A read or write burst is in progress |
| mode | output | 3 | Current state code |
| cmd_accept | output | 1 | Command taken in normal operation at the last edge |
| illegal | output | 1 | Last edge carried an illegal or reserved combination |
| ready | output | 1 | New commands may be issued (IDLE or ACTIVE) |

## Verification
Every result of this block is due exactly one edge after the inputs that cause it. The bench therefore changes inputs at a falling clock edge, waits for the next rising edge, and compares all four outputs at the falling edge that follows, before it applies the next stimulus. The exit window is tracked by a cycle count kept in the bench. As a result, `ready` staying low and the closing edge of the window are both checked on the exact cycle given by `SRX_CYCLES`.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

    localparam int CMD_W  = 3;
    localparam int MODE_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_INHIBIT      = 3'd0,
        CMD_NOP          = 3'd1,
        CMD_ACTIVATE     = 3'd2,
        CMD_READ         = 3'd3,
        CMD_WRITE        = 3'd4,
        CMD_PRECHARGE    = 3'd5,
        CMD_AUTO_REFRESH = 3'd6,
        CMD_LOAD_MODE    = 3'd7
    } cmd_e;

    typedef enum logic [MODE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_ACTIVE  = 3'd1,
        ST_PWRDN   = 3'd2,
        ST_SELFREF = 3'd3,
        ST_SUSPEND = 3'd4,
        ST_SRX     = 3'd5
    } mode_e;

    // {previous level, current level}
    typedef enum logic [1:0] {
        EDGE_LL = 2'b00,
        EDGE_LH = 2'b01,
        EDGE_HL = 2'b10,
        EDGE_HH = 2'b11
    } cke_edge_e;

endpackage

// File: rtl/sdram_cke_hist.sv
module sdram_cke_hist
    import sdram_cke_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke,
    output cke_edge_e edge_kind
);

    logic cke_q;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    assign edge_kind = cke_edge_e'({cke_q, cke});

endmodule

// File: rtl/sdram_srx_window.sv
module sdram_srx_window #(
    parameter int SRX_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic nop_seen,
    output logic last,
    output logic nops_ok
);

    localparam int CW       = $clog2(SRX_CYCLES + 1);
    localparam int NOP_NEED = 2;

    logic [CW-1:0] cnt_q;
    logic [1:0]    nops_q;
    logic [2:0]    nops_now;

    assign nops_now = {1'b0, nops_q} + {2'b00, nop_seen};
    assign last     = active && (cnt_q == CW'(1));
    assign nops_ok  = nops_now >= 3'(NOP_NEED);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            nops_q <= '0;
        end else if (start) begin
            cnt_q  <= CW'(SRX_CYCLES);
            nops_q <= '0;
        end else if (active) begin
            if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
            if (nop_seen && nops_q != 2'd2) nops_q <= nops_q + 2'd1;
        end
    end

    AST_WINDOW_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q != '0)); // R7

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
    import sdram_cke_pkg::*;
#(
    parameter int SRX_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              banks_idle,
    input  logic              rw_active,
    output logic [MODE_W-1:0] mode,
    output logic              cmd_accept,
    output logic              illegal,
    output logic              ready
);

    mode_e     state_q, state_n;
    cke_edge_e edge_kind;
    cmd_e      c;
    logic      quiet, acc_n, ill_n, win_start, win_last, nops_ok;

    assign c     = cmd_e'(cmd);
    assign quiet = (c == CMD_INHIBIT) || (c == CMD_NOP);

    sdram_cke_hist i_hist (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .edge_kind (edge_kind)
    );

    sdram_srx_window #(.SRX_CYCLES(SRX_CYCLES)) i_window (
        .clk      (clk),
        .rst      (rst),
        .start    (win_start),
        .active   (state_q == ST_SRX),
        .nop_seen ((edge_kind == EDGE_HH) && (c == CMD_NOP)),
        .last     (win_last),
        .nops_ok  (nops_ok)
    );

    // Transition decision from the state held before this edge
    always_comb begin
        state_n   = state_q;
        acc_n     = 1'b0;
        ill_n     = 1'b0;
        win_start = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE: begin
                unique case (edge_kind)
                    EDGE_HH: begin
                        acc_n   = 1'b1;
                        state_n = banks_idle ? ST_IDLE : ST_ACTIVE;
                    end
                    EDGE_HL: begin
                        if (rw_active) begin
                            if (c == CMD_WRITE || c == CMD_NOP) state_n = ST_SUSPEND;
                            else                                ill_n   = 1'b1;
                        end else if (banks_idle && quiet) begin
                            state_n = ST_PWRDN;
                        end else if (banks_idle && c == CMD_AUTO_REFRESH) begin
                            state_n = ST_SELFREF;
                        end else begin
                            ill_n = 1'b1;
                        end
                    end
                    default: ill_n = 1'b1;
                endcase
            end
            ST_PWRDN: begin
                if (edge_kind == EDGE_LH && quiet) state_n = ST_IDLE;
                else if (edge_kind != EDGE_LL)     ill_n   = 1'b1;
            end
            ST_SELFREF: begin
                if (edge_kind == EDGE_LH && quiet) begin
                    state_n   = ST_SRX;
                    win_start = 1'b1;
                end else if (edge_kind != EDGE_LL) begin
                    ill_n = 1'b1;
                end
            end
            ST_SUSPEND: begin
                if (edge_kind == EDGE_LH)      state_n = ST_ACTIVE;
                else if (edge_kind != EDGE_LL) ill_n   = 1'b1;
            end
            ST_SRX: begin
                if (edge_kind != EDGE_HH || !quiet) ill_n = 1'b1;
                if (win_last) begin
                    state_n = ST_IDLE;
                    if (!nops_ok) ill_n = 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                ill_n   = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_accept <= 1'b0;
            illegal    <= 1'b0;
            ready      <= 1'b1;
        end else begin
            cmd_accept <= acc_n;
            illegal    <= ill_n;
            ready      <= (state_n == ST_IDLE) || (state_n == ST_ACTIVE);
        end
    end

    assign mode = state_q;

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (edge_kind == EDGE_LL && (state_q == ST_PWRDN || state_q == ST_SELFREF ||
         state_q == ST_SUSPEND)) |=> (mode == $past(mode) && !illegal)); // R2

    AST_PWRDN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE || state_q == ST_ACTIVE) && edge_kind == EDGE_HL &&
         banks_idle && !rw_active && quiet) |=> (mode == ST_PWRDN && !ready)); // R3

    AST_SUSPEND_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSPEND && edge_kind == EDGE_LH) |=> (mode == ST_ACTIVE && ready)); // R6

    AST_SRX_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SRX) |-> !ready); // R7

    AST_ACCEPT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> !illegal); // R10

    AST_ACCEPT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_ACTIVE)); // R10

endmodule

// File: tb/test_sdram_cke_tracker.sv
module test_sdram_cke_tracker;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd1;
    logic       banks_idle = 1'b1;
    logic       rw_active = 1'b0;
    logic [2:0] mode;
    logic       cmd_accept, illegal, ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int m_st, m_cnt, m_nops;
    bit m_prev;

    always #5 clk = ~clk;

    sdram_cke_tracker #(.SRX_CYCLES(N)) i_sdram_cke_tracker (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .banks_idle(banks_idle),
        .rw_active(rw_active), .mode(mode), .cmd_accept(cmd_accept),
        .illegal(illegal), .ready(ready)
    );

    function automatic void model(input int st, input bit kp, input bit k, input int c,
                                  input bit bi, input bit rw, input int cnt, input int nops,
                                  output int nst, output bit acc, output bit ill,
                                  output int ncnt, output int nnops);
        bit q = (c == 0) || (c == 1);
        nst = st; acc = 0; ill = 0; ncnt = cnt; nnops = nops;
        case (st)
            0, 1: begin
                if (kp && k) begin acc = 1; nst = bi ? 0 : 1; end
                else if (kp && !k) begin
                    if (rw) begin if (c == 4 || c == 1) nst = 4; else ill = 1; end
                    else if (bi && q) nst = 2;
                    else if (bi && c == 6) nst = 3;
                    else ill = 1;
                end else ill = 1;
            end
            2: if (!kp && k && q) nst = 0; else if (kp || k) ill = 1;
            3: if (!kp && k && q) begin nst = 5; ncnt = N; nnops = 0; end
               else if (kp || k) ill = 1;
            4: if (!kp && k) nst = 1; else if (kp || k) ill = 1;
            default: begin
                if (!(kp && k) || !q) ill = 1;
                if (kp && k && c == 1) nnops = nops + 1;
                ncnt = cnt - 1;
                if (cnt == 1) begin nst = 0; if (nnops < 2) ill = 1; end
            end
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int st, input bit acc, input bit ill);
        chk(tag, "mode", int'(mode), st);
        chk(tag, "cmd_accept", int'(cmd_accept), int'(acc));
        chk(tag, "illegal", int'(illegal), int'(ill));
        chk(tag, "ready", int'(ready), (st == 0 || st == 1) ? 1 : 0);
    endtask

    task automatic step(input string tag, input bit k, input int c, input bit bi, input bit rw);
        int nst, ncnt, nnops;
        bit acc, ill;
        cke = k; cmd = 3'(c); banks_idle = bi; rw_active = rw;
        model(m_st, m_prev, k, c, bi, rw, m_cnt, m_nops, nst, acc, ill, ncnt, nnops);
        @(posedge clk);
        @(negedge clk);
        check_all(tag, nst, acc, ill);
        m_st = nst; m_prev = k; m_cnt = ncnt; m_nops = nnops;
    endtask

    task automatic do_reset();
        rst = 1'b1; cke = 1'b1; cmd = 3'd1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_prev = 1; m_cnt = 0; m_nops = 0;
        check_all("R1", 0, 0, 0);
    endtask

    task automatic enter_selfref_and_exit();
        step("R3", 1'b0, 6, 1'b1, 1'b0);
        step("R2", 1'b0, 3, 1'b1, 1'b0);
        step("R7", 1'b1, 1, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // previous cke preset high: immediate power-down entry
        step("R1", 1'b0, 1, 1'b1, 1'b0);
        step("R2", 1'b0, 3, 1'b1, 1'b0);
        step("R2", 1'b0, 7, 1'b0, 1'b1);
        step("R5", 1'b1, 0, 1'b1, 1'b0);
        step("R10", 1'b1, 2, 1'b0, 1'b0);
        // clock suspend
        step("R4", 1'b0, 4, 1'b0, 1'b1);
        step("R2", 1'b0, 2, 1'b0, 1'b1);
        step("R6", 1'b1, 3, 1'b0, 1'b1);
        step("R4", 1'b0, 1, 1'b0, 1'b1);
        step("R6", 1'b1, 5, 1'b0, 1'b0);
        step("R10", 1'b1, 5, 1'b1, 1'b0);
        // self refresh with a clean window
        enter_selfref_and_exit();
        for (int i = 0; i < N; i++) step("R7", 1'b1, (i % 2 == 0) ? 1 : 0, 1'b1, 1'b0);
        // window with a single NOP
        enter_selfref_and_exit();
        for (int i = 0; i < N; i++) step("R8", 1'b1, (i == 2) ? 1 : 0, 1'b1, 1'b0);
        // window with a READ inside
        enter_selfref_and_exit();
        for (int i = 0; i < N; i++) step("R8", 1'b1, (i == 3) ? 3 : 1, 1'b1, 1'b0);
        // uncovered combinations
        step("R9", 1'b0, 2, 1'b1, 1'b0);
        step("R9", 1'b0, 1, 1'b1, 1'b0);
        step("R9", 1'b1, 1, 1'b1, 1'b0);
        step("R10", 1'b1, 1, 1'b1, 1'b0);
        step("R3", 1'b0, 0, 1'b1, 1'b0);
        step("R9", 1'b1, 3, 1'b1, 1'b0);
        step("R2", 1'b0, 1, 1'b1, 1'b0);
        step("R5", 1'b1, 1, 1'b1, 1'b0);
        step("R9", 1'b0, 3, 1'b0, 1'b1);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit k, bi, rw;
            int c;
            k  = (($urandom % 100) < 85) ? m_prev : !m_prev;
            c  = (($urandom % 2) == 0) ? 1 : (($urandom % 5) == 0) ? 0 : int'($urandom % 8);
            bi = (($urandom % 10) < 6);
            rw = !bi && (($urandom % 2) == 0);
            step("R11", k, c, bi, rw);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule